// File: doc/BRIEF.md
# Touch Frame Qualifier and Averager

This block sits behind a touch-sampling front end and turns a burst of packed samples into one position report. The front end leaves its samples in a show-ahead FIFO and raises a trigger. The block then reads up to four words. From each word it takes an X code and a Y code and inverts them against the full-scale code. It then checks that the frame is complete and that the pen was still down at the end of it.

A good frame gives a report with touch asserted. The position is the truncated mean of the second and third samples. Any other frame gives a release report. If the FIFO has flagged an overrun when the trigger arrives, the block empties the FIFO and reports nothing for that trigger. Triggers that arrive while a frame is still being handled are dropped.

The FIFO handshake is simple. The word on `fifoData` is valid whenever `fifoEmpty` is low. Holding `fifoPop` high at a rising clock edge consumes that word.

Top module: `touch_report_unit`

## Requirements
- R1: If `fifoOverrun` is high at the edge where a trigger is taken, the block pops words on consecutive cycles until `fifoEmpty` is seen, then returns to idle, and no report strobe is issued for that trigger.
- R2: `fifoPop` is never high while `fifoEmpty` is high. For a non-overrun trigger, the block pops one word per cycle, starting in the cycle after the trigger edge, and stops after four words or at the first empty cycle, whichever comes first.
- R3: The raw X code sits in word bits 25:16 and the raw Y code in bits 9:0. Each is converted to 1023 minus the raw code. The other bits of a word have no effect on the reported position.
- R4: A frame is good only when four words were popped and bit 31 of the fourth word is 0, meaning the pen is still down.
- R5: For a good frame, `rptX` is the sum of the inverted X codes of the second and third words, shifted right by one, so a half is dropped. `rptY` is formed the same way from the Y codes. `rptTouch` is 1.
- R6: Any frame that is not good, including a frame of fewer than four words or an empty FIFO, gives a report with `rptTouch` 0 and `rptX` and `rptY` both 0.
- R7: Each non-overrun trigger gives exactly one `rptValid` pulse, one cycle wide. For a frame of n words (n from 0 to 4), the pulse is visible after the edge n+2 cycles past the trigger edge.
- R8: A trigger seen at any edge where the block is not idle has no effect: it causes no pop, no drain and no report.
- R9: While reset is held, `rptValid`, `rptTouch`, `rptX`, `rptY` and `fifoPop` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Frame-ready trigger from the sampling front end |
| fifoData | input | 32 | Head word of the sample FIFO (show-ahead) |
| fifoEmpty | input | 1 | FIFO holds no words |
| fifoOverrun | input | 1 | FIFO has lost samples |
| fifoPop | output | 1 | Consume the head word at this edge |
| rptValid | output | 1 | One-cycle report strobe |
| rptX | output | 10 | Reported X position |
| rptY | output | 10 | Reported Y position |
| rptTouch | output | 1 | 1 = pen down with valid position, 0 = release |

## Verification
A wrong sample counter or a wrong sequencer state shows up at `fifoPop` within one cycle. Either one word too many or too few leaves the FIFO, and the bench compares the pop line against its model on every cycle. A slot register loaded at the wrong index shows up at the next report as a position that is off by the gap between neighbouring samples. A bad pen-bit capture flips `rptTouch` on that same strobe. A late or duplicated strobe is caught on the exact cycle, because the model predicts the arrival edge from the word count at the trigger.

// File: rtl/touch_rpt_pkg.sv
package touch_rpt_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrFrame;  // start of a new frame: reset count and pen flag
    logic capture;   // head word is being popped into the current slot
    logic emit;      // register the report outputs and pulse the strobe
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_GATHER,
    ST_REPORT
  } seqState_t;

endpackage

// File: rtl/touch_rpt_ctrl.sv
module touch_rpt_ctrl
  import touch_rpt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    trigIn,
  input  logic    fifoEmpty,
  input  logic    fifoOverrun,
  input  logic    frameFull,
  output logic    fifoPop,
  output dpCtrl_t dpCtrl
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    fifoPop   = 1'b0;
    dpCtrl    = '0;
    unique case (state)
      ST_IDLE: begin
        if (trigIn) begin
          dpCtrl.clrFrame = 1'b1;
          stateNext = fifoOverrun ? ST_DRAIN : ST_GATHER;
        end
      end
      ST_DRAIN: begin
        if (fifoEmpty) stateNext = ST_IDLE;
        else           fifoPop   = 1'b1;
      end
      ST_GATHER: begin
        if (fifoEmpty || frameFull) begin
          stateNext = ST_REPORT;
        end else begin
          fifoPop        = 1'b1;
          dpCtrl.capture = 1'b1;
        end
      end
      ST_REPORT: begin
        dpCtrl.emit = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R2: a pop is only issued against a word that is present
  a_r2_pop_has_data: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);

  // R1: a drain that sees an empty FIFO returns to idle and never reports
  a_r1_drain_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && fifoEmpty) |=> (state == ST_IDLE));

  // R1: a drain never reaches the report state
  a_r1_drain_no_report: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN) |=> (state != ST_REPORT));

  // R8: a trigger while busy never restarts a frame
  a_r8_busy_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && trigIn) |=> !($past(state) == ST_DRAIN && state == ST_GATHER));

endmodule

// File: rtl/touch_rpt_dp.sv
module touch_rpt_dp
  import touch_rpt_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int COORD_W    = 10,
  parameter int X_LSB      = 16,
  parameter int Y_LSB      = 0,
  parameter int PEN_BIT    = 31,
  parameter int FRAME_LEN  = 4,
  parameter int AVG_FIRST  = 1,
  parameter int AVG_SECOND = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  fifoData,
  input  dpCtrl_t            dpCtrl,
  output logic               frameFull,
  output logic               rptValid,
  output logic [COORD_W-1:0] rptX,
  output logic [COORD_W-1:0] rptY,
  output logic               rptTouch
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam int N_TAP = 2;
  localparam logic [COORD_W-1:0] FULL_SCALE = {COORD_W{1'b1}};

  logic [CNT_W-1:0]   sampleCnt;
  logic               lastPenUp;
  logic [COORD_W-1:0] tapX [N_TAP];
  logic [COORD_W-1:0] tapY [N_TAP];
  logic [COORD_W-1:0] invX, invY;
  logic [COORD_W:0]   sumX, sumY;
  logic               frameGood;
  logic               unusedWordBits;

  assign invX = FULL_SCALE - fifoData[X_LSB +: COORD_W];
  assign invY = FULL_SCALE - fifoData[Y_LSB +: COORD_W];
  assign unusedWordBits = ^fifoData;

  always_ff @(posedge clk) begin
    if (!rstN || dpCtrl.clrFrame) sampleCnt <= '0;
    else if (dpCtrl.capture)      sampleCnt <= sampleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || dpCtrl.clrFrame) begin
      lastPenUp <= 1'b1;
    end else if (dpCtrl.capture && sampleCnt == CNT_W'(FRAME_LEN - 1)) begin
      lastPenUp <= fifoData[PEN_BIT];
    end
  end

  // Only the averaged slots keep their coordinates
  for (genvar t = 0; t < N_TAP; t++) begin : g_tap
    localparam int SLOT = (t == 0) ? AVG_FIRST : AVG_SECOND;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tapX[t] <= '0;
        tapY[t] <= '0;
      end else if (dpCtrl.capture && sampleCnt == CNT_W'(SLOT)) begin
        tapX[t] <= invX;
        tapY[t] <= invY;
      end
    end
  end

  assign frameFull = (sampleCnt == CNT_W'(FRAME_LEN));
  assign frameGood = frameFull && !lastPenUp;
  assign sumX = {1'b0, tapX[0]} + {1'b0, tapX[1]};
  assign sumY = {1'b0, tapY[0]} + {1'b0, tapY[1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rptValid <= 1'b0;
      rptTouch <= 1'b0;
      rptX     <= '0;
      rptY     <= '0;
    end else begin
      rptValid <= dpCtrl.emit;
      if (dpCtrl.emit) begin
        rptTouch <= frameGood;
        rptX     <= frameGood ? sumX[COORD_W:1] : '0;
        rptY     <= frameGood ? sumY[COORD_W:1] : '0;
      end
    end
  end

  // R2: never more than a frame's worth of words
  a_r2_count_cap: assert property (@(posedge clk) disable iff (!rstN)
    sampleCnt <= CNT_W'(FRAME_LEN));

  // R7: the strobe is one cycle wide
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rptValid |=> !rptValid);

  // R6: a release report carries a zero position
  a_r6_release_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rptValid && !rptTouch) |-> (rptX == '0 && rptY == '0));

  // R4: touch is only reported for a complete frame
  a_r4_touch_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.emit && !frameFull) |=> !rptTouch);

endmodule

// File: rtl/touch_report_unit.sv
module touch_report_unit
  import touch_rpt_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int COORD_W    = 10,
  parameter int X_LSB      = 16,
  parameter int Y_LSB      = 0,
  parameter int PEN_BIT    = 31,
  parameter int FRAME_LEN  = 4,
  parameter int AVG_FIRST  = 1,
  parameter int AVG_SECOND = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigIn,
  input  logic [WORD_W-1:0]  fifoData,
  input  logic               fifoEmpty,
  input  logic               fifoOverrun,
  output logic               fifoPop,
  output logic               rptValid,
  output logic [COORD_W-1:0] rptX,
  output logic [COORD_W-1:0] rptY,
  output logic               rptTouch
);

  dpCtrl_t dpCtrl;
  logic    frameFull;

  touch_rpt_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .trigIn     (trigIn),
    .fifoEmpty  (fifoEmpty),
    .fifoOverrun(fifoOverrun),
    .frameFull  (frameFull),
    .fifoPop    (fifoPop),
    .dpCtrl     (dpCtrl)
  );

  touch_rpt_dp #(
    .WORD_W    (WORD_W),
    .COORD_W   (COORD_W),
    .X_LSB     (X_LSB),
    .Y_LSB     (Y_LSB),
    .PEN_BIT   (PEN_BIT),
    .FRAME_LEN (FRAME_LEN),
    .AVG_FIRST (AVG_FIRST),
    .AVG_SECOND(AVG_SECOND)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .fifoData (fifoData),
    .dpCtrl   (dpCtrl),
    .frameFull(frameFull),
    .rptValid (rptValid),
    .rptX     (rptX),
    .rptY     (rptY),
    .rptTouch (rptTouch)
  );

endmodule

// File: tb/test_touch_report_unit.sv
`timescale 1ns/1ps
module test_touch_report_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigIn = 1'b0;
  logic [31:0] fifoData = '0;
  logic        fifoEmpty = 1'b1;
  logic        fifoOverrun = 1'b0;
  logic        fifoPop;
  logic        rptValid;
  logic [9:0]  rptX, rptY;
  logic        rptTouch;

  always #2.5 clk = ~clk;

  touch_report_unit i_touch_report_unit (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .fifoData(fifoData),
    .fifoEmpty(fifoEmpty), .fifoOverrun(fifoOverrun), .fifoPop(fifoPop),
    .rptValid(rptValid), .rptX(rptX), .rptY(rptY), .rptTouch(rptTouch)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] fq[$];
  bit ovr = 0;
  int cyc = 0;
  int nextFree = 0;
  int popFrom = -1, popTo = -2;
  int expStep = -1;
  int expX = 0, expY = 0, expT = 0;
  bit popPending = 0;
  int reports = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] mkWord(int rx, int ry, bit penUp, bit junk);
    logic [31:0] w;
    w = (32'(rx & 1023) << 16) | 32'(ry & 1023);
    if (penUp) w[31] = 1'b1;
    if (junk)  w = w | 32'h7C00_FC00;
    return w;
  endfunction

  task automatic step(input bit trig);
    @(negedge clk);
    cyc++;
    // outputs after the previous edge
    if (rstN) begin
      chk(rptValid == (cyc == expStep), "R7 strobe timing", rptValid, cyc == expStep);
      if (cyc == expStep) begin
        reports++;
        chk(rptTouch == expT[0], "R4/R6 touch flag", rptTouch, expT);
        chk(rptX == expX, "R3/R5 X position", rptX, expX);
        chk(rptY == expY, "R3/R5 Y position", rptY, expY);
      end
    end
    if (popPending && fq.size() > 0) fq.delete(0);
    fifoData    = (fq.size() > 0) ? fq[0] : 32'h0;
    fifoEmpty   = (fq.size() == 0);
    fifoOverrun = ovr;
    trigIn      = trig;
    if (trig && rstN && cyc >= nextFree) begin
      int n;
      n = fq.size();
      if (ovr) begin
        popFrom = cyc + 1; popTo = cyc + n; nextFree = cyc + n + 2;
      end else begin
        if (n > 4) n = 4;
        popFrom = cyc + 1; popTo = cyc + n; nextFree = cyc + n + 3;
        expStep = cyc + n + 3;
        if (n == 4 && fq[3][31] == 1'b0) begin
          expT = 1;
          expX = ((1023 - int'(fq[1][25:16])) + (1023 - int'(fq[2][25:16]))) / 2;
          expY = ((1023 - int'(fq[1][9:0])) + (1023 - int'(fq[2][9:0]))) / 2;
        end else begin
          expT = 0; expX = 0; expY = 0;
        end
      end
    end
    #1;
    chk(fifoPop == (rstN && cyc >= popFrom && cyc <= popTo), "R1/R2/R8 pop pattern",
        fifoPop, rstN && cyc >= popFrom && cyc <= popTo);
    popPending = fifoPop;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic fire();
    step(1'b1);
    idle(10);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rep0;
    // R9: reset state
    for (int i = 0; i < 3; i++) begin
      step(1'b0);
      chk(!rptValid && !rptTouch && rptX == 0 && rptY == 0 && !fifoPop,
          "R9 reset outputs", {rptValid, rptTouch, fifoPop}, 0);
    end
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R5: good frame, plain values
    fq.push_back(mkWord(100, 10, 0, 0));
    fq.push_back(mkWord(200, 20, 0, 0));
    fq.push_back(mkWord(300, 30, 0, 0));
    fq.push_back(mkWord(400, 41, 0, 0));
    fire();

    // R5: odd sums truncate; extremes of the code range
    fq.push_back(mkWord(0, 1023, 0, 0));
    fq.push_back(mkWord(1, 1023, 0, 0));
    fq.push_back(mkWord(2, 1022, 0, 0));
    fq.push_back(mkWord(3, 0, 0, 0));
    fire();

    // R3: bits outside the fields have no effect
    fq.push_back(mkWord(7, 8, 0, 1));
    fq.push_back(mkWord(511, 512, 0, 1));
    fq.push_back(mkWord(600, 77, 0, 1));
    fq.push_back(mkWord(9, 9, 0, 1));
    fire();

    // R4/R6: pen lifted on the fourth word
    fq.push_back(mkWord(50, 50, 0, 0));
    fq.push_back(mkWord(60, 60, 0, 0));
    fq.push_back(mkWord(70, 70, 0, 0));
    fq.push_back(mkWord(80, 80, 1, 0));
    fire();

    // R6: short frame of two words
    fq.push_back(mkWord(5, 5, 0, 0));
    fq.push_back(mkWord(6, 6, 0, 0));
    fire();

    // R6/R7: empty FIFO still yields a release report
    fire();

    // R2: six words, only four taken
    for (int i = 0; i < 6; i++) fq.push_back(mkWord(100 * i, 50 * i, 0, 0));
    fire();
    chk(fq.size() == 2, "R2 words left behind", fq.size(), 2);
    fq.delete();
    popPending = 0;
    idle(2);

    // R1: overrun drains with no report
    rep0 = reports;
    for (int i = 0; i < 3; i++) fq.push_back(mkWord(i, i, 0, 0));
    ovr = 1;
    fire();
    ovr = 0;
    chk(fq.size() == 0, "R1 drained", fq.size(), 0);
    chk(reports == rep0, "R1 no report", reports - rep0, 0);

    // R8: trigger held high while busy; one report only
    rep0 = reports;
    for (int i = 0; i < 4; i++) fq.push_back(mkWord(20 + i, 30 + i, 0, 0));
    for (int i = 0; i < 4; i++) step(1'b1);
    idle(10);
    chk(reports == rep0 + 1, "R8 single report while busy", reports - rep0, 1);

    // R1: overrun with an empty FIFO
    rep0 = reports;
    ovr = 1;
    fire();
    ovr = 0;
    chk(reports == rep0, "R1 empty overrun no report", reports - rep0, 0);

    // R7: back-to-back frames
    fq.push_back(mkWord(1, 2, 0, 0));
    fq.push_back(mkWord(3, 4, 0, 0));
    fq.push_back(mkWord(5, 6, 0, 0));
    fq.push_back(mkWord(7, 8, 0, 0));
    fire();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule